// File: doc/BRIEF.md
# SDLC Receive Framer

This block turns a serial bit stream into bytes for a bit-oriented synchronous link. One received bit is taken on each clock where `bit_en_i` is high. After reset the framer hunts for an opening flag. Once it is in sync, it discards stuffed zeros and builds bytes least significant bit first. Each byte is presented with a one-cycle character-available strobe.

A closing flag ends the frame. The block then reports the number of complete bytes and the number of leftover bits. The two trailing check bytes are passed through and counted, not checked. A run of seven ones aborts the frame and sends the receiver back to hunt. A separate status bit marks an end-of-poll run. Abort and hunt transitions also pulse a shared external-status line.

Top module: `sdlc_rx_framer`

## Requirements
- R1: While `rst_ni` is low, the framer is in hunt (`hunt_o`=1), every strobe is 0, and `frame_len_o` and `residue_o` are 0.
- R2: In hunt, no received bit produces a character strobe. A flag (a zero, six ones, a zero) ends hunt. `hunt_o` falls, and `ext_stat_o` pulses once, in the cycle after the flag's final zero is taken.
- R3: When in sync, data bits form bytes LSB first (the first data bit lands in `rx_byte_o[0]`). Each byte is shown with a one-cycle `rx_char_avail_o`. Flag bits never reach a byte or raise the strobe.
- R4: A zero received right after five ones inside a frame is discarded and is not counted as data.
- R5: A closing flag after two or more complete bytes raises `eof_o` for one cycle. In that same cycle, `frame_len_o` holds the byte count (check bytes included) and `residue_o` holds the leftover bit count (0 to 7). Both values hold until the next end of frame.
- R6: A closing flag after one complete byte, or after fewer than eight data bits, raises no `eof_o`. Back-to-back flags produce neither a strobe nor an end of frame.
- R7: When not in hunt, the seventh one of a run raises `abort_o` and `ext_stat_o` for one cycle and returns the framer to hunt. The partial frame is dropped without an end of frame.
- R8: Ones that follow the seventh in the same run raise no further `abort_o`. Runs of ones received while in hunt raise none.
- R9: The eighth one of a run that follows a zero raises `eop_o` for one cycle, in any mode. Later ones in that run do not raise it again.
- R10: Clocks with `bit_en_i` low change no state and raise no strobe. A frame whose bits are spread over idle clocks decodes exactly as a contiguous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_bit_i | input | 1 | Received line bit |
| bit_en_i | input | 1 | Take `rx_bit_i` on this clock |
| rx_byte_o | output | 8 | Assembled byte |
| rx_char_avail_o | output | 1 | One-cycle strobe: `rx_byte_o` is valid |
| eof_o | output | 1 | One-cycle end-of-frame strobe |
| frame_len_o | output | LEN_W | Complete bytes in the last reported frame |
| residue_o | output | 3 | Leftover bits in the last reported frame |
| abort_o | output | 1 | One-cycle abort strobe |
| hunt_o | output | 1 | Receiver is hunting for a flag |
| eop_o | output | 1 | One-cycle end-of-poll strobe |
| ext_stat_o | output | 1 | One-cycle external-status event (abort, hunt exit) |

## Verification
The assertions assume that `rx_bit_i` is sampled only when `bit_en_i` is high. They also assume that nothing except a reset forces the framer back into sync, so every strobe is traced to a preceding enabled bit. The bench drives a transmitter model that inserts a zero after every five data ones. Aborts are entered only from a zero-terminated run, and idle gaps are inserted with `bit_en_i` low while `rx_bit_i` keeps toggling. The frame lengths tried cover the reportable and the too-short cases, and the abort tests send runs long enough to cross both the seven-one and the eight-one thresholds.

// File: rtl/sdlc_rx_pkg.sv
package sdlc_rx_pkg;
  localparam int unsigned STUFF_RUN = 5;  // ones before an inserted zero
  localparam int unsigned FLAG_RUN  = 6;  // ones inside a flag
  localparam int unsigned ABORT_RUN = 7;
  localparam int unsigned EOP_RUN   = 8;

  typedef struct packed {
    logic data;     // bit carries payload (or may, until disproved)
    logic stuff;    // inserted zero
    logic sixth;    // sixth one: flag or abort in progress
    logic flag;     // closing zero of a flag
    logic seventh;  // abort threshold
    logic eop;      // end-of-poll threshold
  } bit_kind_t;
endpackage

// File: rtl/sdlc_rx_bit_class.sv
module sdlc_rx_bit_class
  import sdlc_rx_pkg::*;
#(
  parameter int unsigned RUN_W = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      bit_en_i,
  input  logic      rx_bit_i,
  output bit_kind_t kind_o
);
  localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(EOP_RUN);
  localparam logic [RUN_W-1:0] RUN_STF = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] RUN_FLG = RUN_W'(FLAG_RUN);
  localparam logic [RUN_W-1:0] RUN_ABT = RUN_W'(ABORT_RUN);

  logic [RUN_W-1:0] ones_q;
  logic             zero_seen_q;

  always_comb begin
    kind_o.data    = ones_q < RUN_STF;
    kind_o.stuff   = !rx_bit_i && (ones_q == RUN_STF);
    kind_o.sixth   =  rx_bit_i && (ones_q == RUN_STF);
    kind_o.flag    = !rx_bit_i && (ones_q == RUN_FLG);
    kind_o.seventh =  rx_bit_i && (ones_q == RUN_FLG);
    kind_o.eop     =  rx_bit_i && (ones_q == RUN_ABT) && zero_seen_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q      <= '0;
      zero_seen_q <= 1'b0;
    end else if (bit_en_i) begin
      if (rx_bit_i) begin
        if (ones_q != RUN_SAT) ones_q <= ones_q + 1'b1;
      end else begin
        ones_q      <= '0;
        zero_seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sdlc_rx_delay.sv
// Holds the newest DEPTH payload bits so a flag's leading bits can be withdrawn.
module sdlc_rx_delay #(
  parameter int unsigned DEPTH = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic push_i,
  input  logic bit_i,
  input  logic flush_i,
  output logic pop_o,
  output logic pop_bit_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [DEPTH-1:0] dly_q;
  logic [CNT_W-1:0] cnt_q;

  assign pop_o     = push_i && (cnt_q == FULL);
  assign pop_bit_o = dly_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dly_q <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      dly_q <= {bit_i, dly_q[DEPTH-1:1]};
      if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sdlc_rx_byte_asm.sv
module sdlc_rx_byte_asm #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bit_vld_i,
  input  logic             bit_i,
  input  logic             clear_i,
  output logic [7:0]       byte_o,
  output logic             byte_vld_o,
  output logic [LEN_W-1:0] nbytes_o,
  output logic [2:0]       nbits_o
);
  logic [7:0]       sh_q, byte_q;
  logic             vld_q;
  logic [2:0]       nbits_q;
  logic [LEN_W-1:0] nbytes_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      byte_q   <= '0;
      vld_q    <= 1'b0;
      nbits_q  <= '0;
      nbytes_q <= '0;
    end else begin
      vld_q <= 1'b0;
      if (clear_i) begin
        nbits_q  <= '0;
        nbytes_q <= '0;
      end else if (bit_vld_i) begin
        sh_q    <= {bit_i, sh_q[7:1]};
        nbits_q <= nbits_q + 1'b1;
        if (nbits_q == 3'd7) begin
          byte_q <= {bit_i, sh_q[7:1]};
          vld_q  <= 1'b1;
          if (nbytes_q != '1) nbytes_q <= nbytes_q + 1'b1;
        end
      end
    end
  end

  assign byte_o     = byte_q;
  assign byte_vld_o = vld_q;
  assign nbytes_o   = nbytes_q;
  assign nbits_o    = nbits_q;
endmodule

// File: rtl/sdlc_rx_framer.sv
module sdlc_rx_framer
  import sdlc_rx_pkg::*;
#(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_bit_i,
  input  logic             bit_en_i,
  output logic [7:0]       rx_byte_o,
  output logic             rx_char_avail_o,
  output logic             eof_o,
  output logic [LEN_W-1:0] frame_len_o,
  output logic [2:0]       residue_o,
  output logic             abort_o,
  output logic             hunt_o,
  output logic             eop_o,
  output logic             ext_stat_o
);
  localparam int unsigned DLY_DEPTH = FLAG_RUN;  // flag zero + five ones reach the delay
  localparam int unsigned RUN_W     = $clog2(EOP_RUN + 1);
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);

  bit_kind_t        kind;
  logic             hunt_q;
  logic             push, flush, close, abort_det, exit_hunt, asm_clear;
  logic             pop, pop_bit;
  logic [LEN_W-1:0] nbytes;
  logic [2:0]       nbits;
  logic             eof_q, abort_q, eop_q, ext_q;
  logic [LEN_W-1:0] len_q;
  logic [2:0]       res_q;

  sdlc_rx_bit_class #(.RUN_W(RUN_W)) i_class (
    .clk_i, .rst_ni, .bit_en_i, .rx_bit_i, .kind_o(kind)
  );

  always_comb begin
    push      = bit_en_i && !hunt_q && kind.data;
    flush     = bit_en_i && !hunt_q && (kind.sixth || kind.seventh);
    close     = bit_en_i && !hunt_q && kind.flag;
    abort_det = bit_en_i && !hunt_q && kind.seventh;
    exit_hunt = bit_en_i &&  hunt_q && kind.flag;
    asm_clear = close || abort_det || exit_hunt;
  end

  sdlc_rx_delay #(.DEPTH(DLY_DEPTH)) i_delay (
    .clk_i, .rst_ni, .push_i(push), .bit_i(rx_bit_i), .flush_i(flush),
    .pop_o(pop), .pop_bit_o(pop_bit)
  );

  sdlc_rx_byte_asm #(.LEN_W(LEN_W)) i_asm (
    .clk_i, .rst_ni, .bit_vld_i(pop), .bit_i(pop_bit), .clear_i(asm_clear),
    .byte_o(rx_byte_o), .byte_vld_o(rx_char_avail_o),
    .nbytes_o(nbytes), .nbits_o(nbits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hunt_q  <= 1'b1;
      eof_q   <= 1'b0;
      abort_q <= 1'b0;
      eop_q   <= 1'b0;
      ext_q   <= 1'b0;
      len_q   <= '0;
      res_q   <= '0;
    end else begin
      abort_q <= abort_det;
      eop_q   <= bit_en_i && kind.eop;
      ext_q   <= abort_det || exit_hunt;
      eof_q   <= close && (nbytes >= MIN_LEN);
      if (close && (nbytes >= MIN_LEN)) begin
        len_q <= nbytes;
        res_q <= nbits;
      end
      if (abort_det)      hunt_q <= 1'b1;
      else if (exit_hunt) hunt_q <= 1'b0;
    end
  end

  assign hunt_o      = hunt_q;
  assign eof_o       = eof_q;
  assign abort_o     = abort_q;
  assign eop_o       = eop_q;
  assign ext_stat_o  = ext_q;
  assign frame_len_o = len_q;
  assign residue_o   = res_q;
endmodule

// File: rtl/sdlc_rx_framer_chk.sv
module sdlc_rx_framer_chk #(
  parameter int unsigned LEN_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rx_bit_i,
  input logic             bit_en_i,
  input logic [7:0]       rx_byte_o,
  input logic             rx_char_avail_o,
  input logic             eof_o,
  input logic [LEN_W-1:0] frame_len_o,
  input logic [2:0]       residue_o,
  input logic             abort_o,
  input logic             hunt_o,
  input logic             eop_o,
  input logic             ext_stat_o
);
  AST_HUNT_EXIT_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hunt_o) |-> ext_stat_o && !abort_o);  // R2
  AST_CHAR_NOT_IN_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_char_avail_o |-> !hunt_o);  // R3
  AST_EOF_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> (frame_len_o >= LEN_W'(2)) && !hunt_o);  // R5
  AST_EOF_NO_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> !rx_char_avail_o);  // R6
  AST_ABORT_TO_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> hunt_o && ext_stat_o && !eof_o);  // R7
  AST_ABORT_FROM_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !$past(hunt_o));  // R8
  AST_EOP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |=> !eop_o);  // R9
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(bit_en_i) |-> !(rx_char_avail_o || eof_o || abort_o || eop_o || ext_stat_o));  // R10
endmodule

bind sdlc_rx_framer sdlc_rx_framer_chk #(.LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_sdlc_rx_framer.sv
`timescale 1ns/1ps
module test_sdlc_rx_framer;
  localparam int unsigned LEN_W = 12;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             rx_bit = 1'b1;
  logic             bit_en = 1'b0;
  logic [7:0]       rx_byte;
  logic             char_avail, eof, abort_s, hunt, eop, ext_stat;
  logic [LEN_W-1:0] frame_len;
  logic [2:0]       residue;

  always #5 clk = ~clk;

  sdlc_rx_framer #(.LEN_W(LEN_W)) i_sdlc_rx_framer (
    .clk_i(clk), .rst_ni, .rx_bit_i(rx_bit), .bit_en_i(bit_en),
    .rx_byte_o(rx_byte), .rx_char_avail_o(char_avail), .eof_o(eof),
    .frame_len_o(frame_len), .residue_o(residue), .abort_o(abort_s),
    .hunt_o(hunt), .eop_o(eop), .ext_stat_o(ext_stat)
  );

  int n_checks = 0, n_fail = 0;
  int n_char, n_eof, n_abort, n_eop, n_ext, n_idle_strobe, tx_ones;
  logic [7:0] got [0:15];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    n_char = 0; n_eof = 0; n_abort = 0; n_eop = 0; n_ext = 0; n_idle_strobe = 0;
  endtask

  task automatic sample(input bit idle);
    if (char_avail) begin
      if (n_char < 16) got[n_char] = rx_byte;
      n_char++;
    end
    if (eof) n_eof++;
    if (abort_s) n_abort++;
    if (eop) n_eop++;
    if (ext_stat) n_ext++;
    if (idle && (char_avail || eof || abort_s || eop || ext_stat)) n_idle_strobe++;
  endtask

  task automatic step_bit(input logic b);
    rx_bit = b; bit_en = 1'b1;
    @(posedge clk); #2;
    sample(1'b0);
  endtask

  task automatic idle(input int n);
    bit_en = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_bit = ~rx_bit;
      @(posedge clk); #2;
      sample(1'b1);
    end
  endtask

  task automatic send_flag();
    step_bit(1'b0);
    for (int i = 0; i < 6; i++) step_bit(1'b1);
    step_bit(1'b0);
    tx_ones = 0;
  endtask

  task automatic send_bits(input logic [7:0] v, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step_bit(v[i]);
      if (gap > 0) idle(gap);
      if (v[i]) begin
        tx_ones++;
        if (tx_ones == 5) begin step_bit(1'b0); tx_ones = 0; end
      end else tx_ones = 0;
    end
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) step_bit(1'b1);
    tx_ones = 0;
  endtask

  task automatic t_reset();
    check(hunt == 1'b1, "R1 hunt", hunt, 1);
    check(!char_avail && !eof && !abort_s && !eop && !ext_stat, "R1 strobes", 1, 0);
    check(frame_len == 0 && residue == 0, "R1 len/res", int'(frame_len), 0);
  endtask

  task automatic t_hunt();
    clear_mon();
    send_bits(8'h5A, 8, 0); send_bits(8'h3C, 8, 0); send_bits(8'hE6, 8, 0);
    check(n_char == 0, "R2 no char in hunt", n_char, 0);
    check(hunt == 1'b1, "R2 still hunting", hunt, 1);
    send_flag();
    check(hunt == 1'b0, "R2 hunt exit", hunt, 0);
    check(n_ext == 1, "R2 ext on exit", n_ext, 1);
  endtask

  task automatic t_frame4();
    logic [7:0] exp [0:3] = '{8'h3C, 8'hA5, 8'hFF, 8'h7E};
    clear_mon();
    for (int i = 0; i < 4; i++) send_bits(exp[i], 8, 0);
    send_flag();
    check(n_char == 4, "R3 byte count", n_char, 4);
    for (int i = 0; i < 4; i++)
      check(got[i] == exp[i], (i >= 2) ? "R4 stuffed byte" : "R3 byte value", got[i], exp[i]);
    check(n_eof == 1, "R5 eof", n_eof, 1);
    check(frame_len == 4 && residue == 0, "R5 len4", int'(frame_len), 4);
  endtask

  task automatic t_residue();
    clear_mon();
    send_bits(8'h81, 8, 0); send_bits(8'h42, 8, 0); send_bits(8'h05, 3, 0);
    send_flag();
    check(n_eof == 1, "R5 eof residue", n_eof, 1);
    check(frame_len == 2, "R5 len2", int'(frame_len), 2);
    check(residue == 3, "R5 residue", int'(residue), 3);
  endtask

  task automatic t_short();
    clear_mon();
    send_bits(8'h55, 8, 0); send_flag();
    check(n_char == 1, "R6 one byte char", n_char, 1);
    check(n_eof == 0, "R6 one byte no eof", n_eof, 0);
    clear_mon();
    send_bits(8'h15, 5, 0); send_flag();
    check(n_eof == 0 && n_char == 0, "R6 bits only", n_eof + n_char, 0);
    clear_mon();
    send_flag(); send_flag(); send_flag();
    check(n_eof == 0 && n_char == 0, "R6 back-to-back flags", n_eof + n_char, 0);
    check(frame_len == 2 && residue == 3, "R6 len held", int'(frame_len), 2);
  endtask

  task automatic t_gap();
    clear_mon();
    send_bits(8'hC3, 8, 3); send_bits(8'h0F, 8, 2);
    idle(4); send_flag();
    check(n_char == 2 && got[0] == 8'hC3 && got[1] == 8'h0F, "R10 gapped bytes", got[0], 8'hC3);
    check(n_eof == 1 && frame_len == 2, "R10 gapped eof", n_eof, 1);
    check(n_idle_strobe == 0, "R10 idle quiet", n_idle_strobe, 0);
  endtask

  task automatic t_abort();
    clear_mon();
    send_bits(8'h12, 8, 0); send_bits(8'h34, 8, 0);
    send_ones(7);
    check(n_abort == 1, "R7 abort", n_abort, 1);
    check(hunt == 1'b1, "R7 back to hunt", hunt, 1);
    check(n_ext == 1, "R7 ext on abort", n_ext, 1);
    check(n_eop == 0, "R9 no eop at seven", n_eop, 0);
    send_ones(10);
    check(n_abort == 1, "R8 single abort per run", n_abort, 1);
    check(n_eop == 1, "R9 eop once", n_eop, 1);
    send_flag();
    check(n_eof == 0, "R7 frame dropped", n_eof, 0);
    check(hunt == 1'b0 && n_ext == 2, "R2 resync after abort", n_ext, 2);
  endtask

  task automatic t_hunt_ones();
    clear_mon();
    send_ones(7);
    check(n_abort == 1 && hunt == 1'b1, "R7 abort from idle sync", n_abort, 1);
    clear_mon();
    step_bit(1'b0); send_ones(9);
    check(n_abort == 0, "R8 no abort in hunt", n_abort, 0);
    check(n_eop == 1, "R9 eop in hunt", n_eop, 1);
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    tx_ones = 0;
    clear_mon();
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #2;
    t_hunt();
    t_frame4();
    t_residue();
    t_short();
    t_gap();
    t_abort();
    t_hunt_ones();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule